// File: doc/BRIEF.md
# Reset-Time Port Option Loader

This block sits between the program ROM, the CPU core and the port pad logic of a small 8-bit controller. The top 256 bytes of the 32 KB program space are reserved for configuration. When reset is released, a sequencer reads the option bytes it needs from that area, one per cycle, through the synchronous ROM read port. It latches a per-pin option for port 0, port 1 and port 7, and only then raises a ready signal that lets the CPU core out of reset. From that point the CPU starts fetching at address 0000h.

While reset is low, and until loading has finished, every port output is reported as open-drain and every pull-up as disabled. The pad logic therefore sees a safe state whatever the ROM holds. Once the block is ready, it hands the ROM port to the CPU. Any fetch that falls inside the option area returns a fixed fill value, so configuration bytes can never be executed or read as program data.

Each option byte sits at a fixed offset from 7F00h. Bytes 0 to 7 configure the port 0 pins 0 to 7, bytes 8 to 15 the port 1 pins 0 to 7, and bytes 16 to 19 the port 7 pins 0 to 3.

Top module: `optld_top`

## Requirements
- R1: While `rst_n` is low, `opt_ready`, `rom_rd` and every bit of `p0_cmos`, `p1_cmos`, `p0_pu_fix`, `p1_pu_fix`, `p0_pu_prog`, `p1_pu_prog` and `p7_pu` are 0, and `cpu_rdata` is FFh.
- R2: In the cycle right after `rst_n` rises, `rom_rd` is 1 and `rom_addr` is 7F00h. The address then advances by one on each rising clock edge until 7F13h (20 bytes).
- R3: `opt_ready` is still 0 after the 20th rising edge that follows the release of reset, and is 1 after the 21st.
- R4: For a port 0 or port 1 pin, bits [1:0] of its option byte select the mode:
  - 00: open-drain with no pull-up.
  - 01: CMOS with a fixed pull-up.
  - 10: open-drain with a programmable pull-up.
  - 11: CMOS with a programmable pull-up.

  In each case `pX_cmos` is bit 0, `pX_pu_fix` is 1 only for code 01, and `pX_pu_prog` is bit 1.
- R5: Bit 0 of the option byte for port 7 pin i (byte 16+i) drives `p7_pu[i]`, where 1 means the pull-up is present.
- R6: Bits [7:2] of port 0 and port 1 option bytes, and bits [7:1] of port 7 option bytes, have no effect on any output.
- R7: Until `opt_ready` is 1, all CMOS and pull-up outputs stay 0 (open-drain, no pull-up), including during the load.
- R8: Once `opt_ready` is 1, it and all option outputs hold their values until reset is asserted again, whatever the CPU fetches.
- R9: While `opt_ready` is 1, `rom_addr` equals `cpu_addr` and `rom_rd` equals `cpu_rd`. A read below 7F00h returns the ROM byte on `cpu_rdata` one cycle after the request.
- R10: While `opt_ready` is 1, a read of any address from 7F00h to 7FFFh returns FFh on `cpu_rdata` one cycle after the request, in place of the ROM byte.
- R11: Asserting `rst_n` low while the block is ready clears `opt_ready` and forces the outputs to open-drain at once, without waiting for a clock edge. The next release reloads the options from the ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | 15 | ROM read address |
| rom_rd | output | 1 | ROM read strobe |
| rom_rdata | input | 8 | ROM data, valid one cycle after the strobe |
| cpu_addr | input | 15 | CPU fetch address |
| cpu_rd | input | 1 | CPU fetch strobe |
| cpu_rdata | output | 8 | Fetch data returned to the CPU |
| opt_ready | output | 1 | Options latched; CPU released from reset |
| p0_cmos | output | 8 | Port 0 output type per pin (1 = CMOS, 0 = open-drain) |
| p0_pu_fix | output | 8 | Port 0 fixed pull-up enabled per pin |
| p0_pu_prog | output | 8 | Port 0 pull-up under program control per pin |
| p1_cmos | output | 8 | Port 1 output type per pin (1 = CMOS, 0 = open-drain) |
| p1_pu_fix | output | 8 | Port 1 fixed pull-up enabled per pin |
| p1_pu_prog | output | 8 | Port 1 pull-up under program control per pin |
| p7_pu | output | 4 | Port 7 input pull-up present per pin |

## Verification
The load is repeated with six ROM images:
- Uniform images of codes 00, 01, 10 and 11 separate each mode decode from its neighbours. Three of them carry set upper bits, which would show any leak from the ignored bits.
- Two images give every byte a different value, which exposes any swap of byte order, port offset or pin index.

Each reload starts by pulling reset while the block is ready. This shows that the latched options clear and the address sequence restarts. Fetches at 7EFFh, 7F00h and 7FFFh bracket the edge of the protected area, and fetches at ordinary program addresses confirm that ROM data passes through unchanged.

// File: rtl/optld_pkg.sv
package optld_pkg;

    // Sequencer phase: reading option bytes, or options latched and CPU released.
    typedef enum logic {
        PH_LOAD  = 1'b0,
        PH_READY = 1'b1
    } ld_phase_e;

    // Two-bit mode code for a bidirectional port pin: bit0 = CMOS drive, bit1 = programmable pull-up.
    typedef enum logic [1:0] {
        PM_OD_NOPU   = 2'b00,
        PM_CMOS_FIX  = 2'b01,
        PM_OD_PROG   = 2'b10,
        PM_CMOS_PROG = 2'b11
    } pin_mode_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/optld_seq.sv
module optld_seq
    import optld_pkg::*;
#(
    parameter int                ADDR_W    = 15,
    parameter int                NUM_BYTES = 20,
    parameter logic [ADDR_W-1:0] BASE      = 15'h7F00
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    rom_code,
    output logic [ADDR_W-1:0]             ld_addr,
    output logic                          ld_rd,
    output logic                          cap_en,
    output logic [$clog2(NUM_BYTES)-1:0]  cap_idx,
    output logic [1:0]                    cap_code,
    output logic                          ready
);

    localparam int IDX_W = $clog2(NUM_BYTES);
    localparam int CNT_W = $clog2(NUM_BYTES + 1);
    localparam logic [CNT_W-1:0] ISSUE_END = CNT_W'(NUM_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_BYTES - 1);

    typedef struct packed {
        ld_phase_e        phase;
        logic [CNT_W-1:0] issue;
        logic             pend;
        logic [IDX_W-1:0] pend_idx;
    } seq_t;

    seq_t s_d, s_q;
    logic issue_now;

    always_comb begin
        s_d       = s_q;
        issue_now = rst_n && (s_q.phase == PH_LOAD) && (s_q.issue < ISSUE_END);

        // Issue one read per cycle; the ROM answers on the next edge.
        if (issue_now) begin
            s_d.issue    = s_q.issue + 1'b1;
            s_d.pend     = 1'b1;
            s_d.pend_idx = IDX_W'(s_q.issue);
        end else begin
            s_d.pend = 1'b0;
        end

        // The answer to the last request completes the load.
        if (s_q.pend && (s_q.pend_idx == LAST_IDX)) begin
            s_d.phase = PH_READY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ld_addr  = BASE + ADDR_W'(s_q.issue);
    assign ld_rd    = issue_now;
    assign cap_en   = s_q.pend;
    assign cap_idx  = s_q.pend_idx;
    assign cap_code = rom_code;
    assign ready    = (s_q.phase == PH_READY);

endmodule

// File: rtl/optld_bank.sv
module optld_bank
    import optld_pkg::*;
#(
    parameter int P0_W  = 8,
    parameter int P1_W  = 8,
    parameter int P7_W  = 4,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [1:0]       cap_code,
    output logic [P0_W-1:0]  p0_cmos,
    output logic [P0_W-1:0]  p0_pu_fix,
    output logic [P0_W-1:0]  p0_pu_prog,
    output logic [P1_W-1:0]  p1_cmos,
    output logic [P1_W-1:0]  p1_pu_fix,
    output logic [P1_W-1:0]  p1_pu_prog,
    output logic [P7_W-1:0]  p7_pu
);

    localparam int P1_OFS = P0_W;
    localparam int P7_OFS = P0_W + P1_W;

    typedef struct packed {
        logic [P0_W-1:0][1:0] p0;
        logic [P1_W-1:0][1:0] p1;
        logic [P7_W-1:0]      p7;
    } bank_t;

    bank_t b_d, b_q;
    logic  live;

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < P0_W; i++) begin
            if (cap_en && (cap_idx == IDX_W'(i))) b_d.p0[i] = cap_code;
        end
        for (int i = 0; i < P1_W; i++) begin
            if (cap_en && (cap_idx == IDX_W'(P1_OFS + i))) b_d.p1[i] = cap_code;
        end
        for (int i = 0; i < P7_W; i++) begin
            if (cap_en && (cap_idx == IDX_W'(P7_OFS + i))) b_d.p7[i] = cap_code[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    // Outputs are held in the safe state until the whole set is latched.
    assign live = ready && rst_n;

    for (genvar g = 0; g < P0_W; g++) begin : g_p0
        assign p0_cmos[g]    = live && b_q.p0[g][0];
        assign p0_pu_fix[g]  = live && (b_q.p0[g] == PM_CMOS_FIX);
        assign p0_pu_prog[g] = live && b_q.p0[g][1];
    end

    for (genvar g = 0; g < P1_W; g++) begin : g_p1
        assign p1_cmos[g]    = live && b_q.p1[g][0];
        assign p1_pu_fix[g]  = live && (b_q.p1[g] == PM_CMOS_FIX);
        assign p1_pu_prog[g] = live && b_q.p1[g][1];
    end

    for (genvar g = 0; g < P7_W; g++) begin : g_p7
        assign p7_pu[g] = live && b_q.p7[g];
    end

endmodule

// File: rtl/optld_fetch.sv
module optld_fetch
    import optld_pkg::*;
#(
    parameter int                ADDR_W = 15,
    parameter logic [ADDR_W-1:0] BASE   = 15'h7F00,
    parameter logic [BYTE_W-1:0] FILL   = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              ld_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic [BYTE_W-1:0] rom_rdata,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_rd,
    output logic [BYTE_W-1:0] cpu_rdata
);

    typedef struct packed {
        logic blocked;
    } fetch_t;

    fetch_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        // Remember whether the read now in flight targets the reserved area.
        if (ready && cpu_rd) f_d.blocked = (cpu_addr >= BASE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign rom_addr  = ready ? cpu_addr : ld_addr;
    assign rom_rd    = ready ? cpu_rd   : ld_rd;
    assign cpu_rdata = (!ready || f_q.blocked) ? FILL : rom_rdata;

endmodule

// File: rtl/optld_top.sv
module optld_top
    import optld_pkg::*;
#(
    parameter int                ADDR_W    = 15,
    parameter int                OPT_BYTES = 256,
    parameter int                P0_W      = 8,
    parameter int                P1_W      = 8,
    parameter int                P7_W      = 4,
    parameter logic [BYTE_W-1:0] FILL      = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_rd,
    input  logic [BYTE_W-1:0] rom_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              opt_ready,
    output logic [P0_W-1:0]   p0_cmos,
    output logic [P0_W-1:0]   p0_pu_fix,
    output logic [P0_W-1:0]   p0_pu_prog,
    output logic [P1_W-1:0]   p1_cmos,
    output logic [P1_W-1:0]   p1_pu_fix,
    output logic [P1_W-1:0]   p1_pu_prog,
    output logic [P7_W-1:0]   p7_pu
);

    localparam logic [ADDR_W-1:0] BASE = ADDR_W'((1 << ADDR_W) - OPT_BYTES);
    localparam int NUM_BYTES = P0_W + P1_W + P7_W;
    localparam int IDX_W     = $clog2(NUM_BYTES);

    logic [ADDR_W-1:0] ld_addr;
    logic              ld_rd;
    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic [1:0]        cap_code;
    logic              ready;

    optld_seq #(
        .ADDR_W    (ADDR_W),
        .NUM_BYTES (NUM_BYTES),
        .BASE      (BASE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rom_code (rom_rdata[1:0]),
        .ld_addr  (ld_addr),
        .ld_rd    (ld_rd),
        .cap_en   (cap_en),
        .cap_idx  (cap_idx),
        .cap_code (cap_code),
        .ready    (ready)
    );

    optld_bank #(
        .P0_W  (P0_W),
        .P1_W  (P1_W),
        .P7_W  (P7_W),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready      (ready),
        .cap_en     (cap_en),
        .cap_idx    (cap_idx),
        .cap_code   (cap_code),
        .p0_cmos    (p0_cmos),
        .p0_pu_fix  (p0_pu_fix),
        .p0_pu_prog (p0_pu_prog),
        .p1_cmos    (p1_cmos),
        .p1_pu_fix  (p1_pu_fix),
        .p1_pu_prog (p1_pu_prog),
        .p7_pu      (p7_pu)
    );

    optld_fetch #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .FILL   (FILL)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .ready     (ready),
        .ld_addr   (ld_addr),
        .ld_rd     (ld_rd),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .rom_rdata (rom_rdata),
        .rom_addr  (rom_addr),
        .rom_rd    (rom_rd),
        .cpu_rdata (cpu_rdata)
    );

    assign opt_ready = ready && rst_n;

endmodule

// File: rtl/optld_chk.sv
module optld_chk #(
    parameter int                ADDR_W = 15,
    parameter logic [ADDR_W-1:0] BASE   = 15'h7F00,
    parameter logic [7:0]        FILL   = 8'hFF,
    parameter int                P0_W   = 8,
    parameter int                P1_W   = 8,
    parameter int                P7_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_rd,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rd,
    input logic [7:0]        cpu_rdata,
    input logic              opt_ready,
    input logic [P0_W-1:0]   p0_cmos,
    input logic [P0_W-1:0]   p0_pu_fix,
    input logic [P0_W-1:0]   p0_pu_prog,
    input logic [P1_W-1:0]   p1_cmos,
    input logic [P1_W-1:0]   p1_pu_fix,
    input logic [P1_W-1:0]   p1_pu_prog,
    input logic [P7_W-1:0]   p7_pu
);

    logic safe_state;
    assign safe_state = (p0_cmos == '0) && (p1_cmos == '0) && (p0_pu_fix == '0) &&
                        (p1_pu_fix == '0) && (p0_pu_prog == '0) && (p1_pu_prog == '0) &&
                        (p7_pu == '0);

    assert_safe_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> (safe_state && !opt_ready && !rom_rd && cpu_rdata == FILL));

    assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && !opt_ready && !$past(rom_rd)) |-> (rom_addr == BASE));

    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && !opt_ready && $past(rom_rd) && !$past(opt_ready))
        |-> (rom_addr == $past(rom_addr) + 1'b1));

    assert_safe_until_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !opt_ready |-> safe_state);

    assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(opt_ready) |-> opt_ready);

    assert_opts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_ready && $past(opt_ready)) |->
        ($stable(p0_cmos) && $stable(p0_pu_fix) && $stable(p0_pu_prog) &&
         $stable(p1_cmos) && $stable(p1_pu_fix) && $stable(p1_pu_prog) && $stable(p7_pu)));

    assert_cpu_owns_rom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        opt_ready |-> (rom_addr == cpu_addr && rom_rd == cpu_rd));

    assert_area_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (opt_ready && $past(opt_ready) && $past(cpu_rd) && ($past(cpu_addr) >= BASE))
        |-> (cpu_rdata == FILL));

endmodule

bind optld_top optld_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .FILL   (FILL),
    .P0_W   (P0_W),
    .P1_W   (P1_W),
    .P7_W   (P7_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rom_addr   (rom_addr),
    .rom_rd     (rom_rd),
    .cpu_addr   (cpu_addr),
    .cpu_rd     (cpu_rd),
    .cpu_rdata  (cpu_rdata),
    .opt_ready  (opt_ready),
    .p0_cmos    (p0_cmos),
    .p0_pu_fix  (p0_pu_fix),
    .p0_pu_prog (p0_pu_prog),
    .p1_cmos    (p1_cmos),
    .p1_pu_fix  (p1_pu_fix),
    .p1_pu_prog (p1_pu_prog),
    .p7_pu      (p7_pu)
);

// File: tb/optld_top_tb.sv
module optld_top_tb;

    localparam int         CLK_PERIOD = 10;
    localparam logic [14:0] BASE      = 15'h7F00;
    localparam int         NBYTES     = 20;

    // Stimulus vectors {mix, seed}: option byte i = seed ^ (mix ? i*29 : 0).
    localparam logic [8:0] VEC [6] = '{
        {1'b0, 8'h00},   // all code 00
        {1'b0, 8'hFD},   // all code 01, upper bits set (R6)
        {1'b0, 8'hFE},   // all code 10, upper bits set (R6)
        {1'b0, 8'hFF},   // all code 11
        {1'b1, 8'h00},   // every byte different
        {1'b1, 8'h6B}    // every byte different, other phase
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] rom_addr;
    logic        rom_rd;
    logic [7:0]  rom_q = 8'h00;
    logic [14:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        opt_ready;
    logic [7:0]  p0_cmos, p0_pu_fix, p0_pu_prog, p1_cmos, p1_pu_fix, p1_pu_prog;
    logic [3:0]  p7_pu;

    logic [7:0]  seed_v = 8'h00;
    logic        mix_v = 1'b0;
    int          n_tests = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    optld_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rom_addr   (rom_addr),
        .rom_rd     (rom_rd),
        .rom_rdata  (rom_q),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_rdata  (cpu_rdata),
        .opt_ready  (opt_ready),
        .p0_cmos    (p0_cmos),
        .p0_pu_fix  (p0_pu_fix),
        .p0_pu_prog (p0_pu_prog),
        .p1_cmos    (p1_cmos),
        .p1_pu_fix  (p1_pu_fix),
        .p1_pu_prog (p1_pu_prog),
        .p7_pu      (p7_pu)
    );

    function automatic logic [7:0] opt_byte(int idx);
        return seed_v ^ (mix_v ? 8'((idx * 29) & 255) : 8'h00);
    endfunction

    function automatic logic [7:0] rom_byte(logic [14:0] a);
        if (a >= BASE) begin
            if (int'(a - BASE) < NBYTES) return opt_byte(int'(a - BASE));
            return 8'hC3;
        end
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    // Synchronous ROM model: one cycle of read latency.
    always @(posedge clk) if (rom_rd) rom_q <= rom_byte(rom_addr);

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_safe(string req);
        check(req, "p0_cmos", 32'(p0_cmos), 0);
        check(req, "p1_cmos", 32'(p1_cmos), 0);
        check(req, "pull-ups", 32'({p0_pu_fix, p1_pu_fix, p0_pu_prog, p1_pu_prog, p7_pu}), 0);
    endtask

    task automatic check_options();
        logic [7:0] e0c, e0f, e0p, e1c, e1f, e1p;
        logic [3:0] e7;
        for (int i = 0; i < 8; i++) begin
            logic [1:0] c0, c1;
            c0 = opt_byte(i)[1:0];
            c1 = opt_byte(8 + i)[1:0];
            e0c[i] = c0[0]; e0f[i] = (c0 == 2'b01); e0p[i] = c0[1];
            e1c[i] = c1[0]; e1f[i] = (c1 == 2'b01); e1p[i] = c1[1];
        end
        for (int i = 0; i < 4; i++) e7[i] = opt_byte(16 + i)[0];
        check("R4", "p0_cmos", 32'(p0_cmos), 32'(e0c));
        check("R4", "p0_pu_fix", 32'(p0_pu_fix), 32'(e0f));
        check("R4", "p0_pu_prog", 32'(p0_pu_prog), 32'(e0p));
        check("R4", "p1_cmos", 32'(p1_cmos), 32'(e1c));
        check("R4", "p1_pu_fix", 32'(p1_pu_fix), 32'(e1f));
        check("R4", "p1_pu_prog", 32'(p1_pu_prog), 32'(e1p));
        check("R5", "p7_pu", 32'(p7_pu), 32'(e7));
    endtask

    task automatic fetch(logic [14:0] a, string req, logic [7:0] exp);
        cpu_addr = a;
        cpu_rd   = 1'b1;
        #1;
        check("R9", "rom_addr follows cpu", 32'(rom_addr), 32'(a));
        @(negedge clk);
        check(req, "cpu_rdata", 32'(cpu_rdata), 32'(exp));
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", "opt_ready in reset", 32'(opt_ready), 0);
        check("R1", "rom_rd in reset", 32'(rom_rd), 0);
        check("R1", "cpu_rdata in reset", 32'(cpu_rdata), 32'hFF);
        check_safe("R1");

        for (int v = 0; v < 6; v++) begin
            if (v > 0) begin
                // R11: pull reset while ready; outputs drop without a clock edge.
                @(negedge clk);
                check("R11", "ready before reset", 32'(opt_ready), 1);
                rst_n = 1'b0;
                #1;
                check("R11", "ready after reset", 32'(opt_ready), 0);
                check_safe("R11");
                check("R1", "rom_rd in reset", 32'(rom_rd), 0);
                repeat (2) @(negedge clk);
            end
            {mix_v, seed_v} = VEC[v];
            cpu_rd = 1'b0;
            @(negedge clk);
            rst_n = 1'b1;
            for (int k = 0; k < NBYTES; k++) begin
                #1;
                check("R2", "rom_rd during load", 32'(rom_rd), 1);
                check("R2", "load address", 32'(rom_addr), 32'(BASE) + k);
                if (k == 10) check_safe("R7");
                @(negedge clk);
            end
            #1;
            check("R3", "ready after 20 edges", 32'(opt_ready), 0);
            check_safe("R7");
            @(negedge clk);
            #1;
            check("R3", "ready after 21 edges", 32'(opt_ready), 1);
            check_options();   // also covers R6 for vectors with upper bits set
        end

        // Fetch phase on the last image.
        @(negedge clk);
        fetch(15'h0000, "R9", rom_byte(15'h0000));
        fetch(15'h1234, "R9", rom_byte(15'h1234));
        fetch(15'h7EFF, "R9", rom_byte(15'h7EFF));
        fetch(15'h7F00, "R10", 8'hFF);
        fetch(15'h7F05, "R10", 8'hFF);
        fetch(15'h7FFF, "R10", 8'hFF);
        fetch(15'h2000, "R9", rom_byte(15'h2000));
        cpu_rd = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R8", "ready held", 32'(opt_ready), 1);
        check_options();   // R8: unchanged after fetches inside the option area

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule